// File: doc/BRIEF.md
# Infrared Burst Pattern Timer

This block times the on and off segments of an infrared remote-control transmission. A controller writes a 10-bit word into it. The low nine bits are a count of machine cycles. The top bit decides whether the segment is a carrier burst or a silent gap. A free-running prescaler divides the oscillator clock by eight to make the machine cycle. The count steps down once per machine cycle, and the segment ends on the tick that finds the count already at zero.

During a carrier segment the block gates a free-running carrier onto the infrared drive output `rem`. The carrier is either a 50% square wave at the oscillator frequency divided by 8, or a one-third-duty wave at the oscillator frequency divided by 12. At the same time the active-low `sout_n` indicator is pulled low. During a silent segment `rem` stays low and `sout_n` stays high.

A `done` level tells the controller that the counter is idle. A one-clock `done_pulse` marks the end of each segment. Segments can be chained with no gap: if the next word is written on the expiring tick, the carrier and the indicator run on without a break.

Top module: `ir_burst_timer`

## Requirements
- R1: While `rst` is high and after it, with no load, `rem` is 0, `sout_n` is 1, `done` is 1 and `done_pulse` is 0. Reset clears all ten timer bits, also in the middle of a burst.
- R2: Machine ticks occur every 8 clocks, the first on the 8th rising edge after `rst` falls. A load of count N (`load_val[8:0]`) on a tick edge keeps the counter active for exactly (N+1)*8 clocks.
- R3: With `load_val[9]`=1, `sout_n` is low for the whole active period. `rem` carries the selected carrier then. Both outputs are registered and lag the counter state by one clock.
- R4: With `load_val[9]`=0, `rem` stays 0 and `sout_n` stays 1 for the whole active period, while `done` is 0.
- R5: With `car_sel`=0 the carrier has period 8 with 4 clocks high, so a burst of whole machine cycles is high for exactly half its clocks.
- R6: With `car_sel`=1 the carrier has period 12 with 4 clocks high, so no high run exceeds 4 clocks and any 24-clock burst is high for 8 clocks.
- R7: `done_pulse` is high for exactly one clock when a segment expires, and `done` is high whenever the counter is idle.
- R8: While `run` is 0 the count is frozen and `rem` is 0 with `sout_n` 1. Raising `run` resumes the count where it stopped.
- R9: A load on the expiring tick continues the burst with no idle clock and no `done_pulse`.
- R10: `rem` is never high while `sout_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-clock strobe that writes `load_val` into the timer |
| load_val | input | 10 | Bit 9 is carrier enable; bits 8:0 are the machine-cycle count |
| run | input | 1 | 1 lets the count proceed, 0 freezes it |
| car_sel | input | 1 | 0 selects divide-by-8 carrier, 1 selects divide-by-12 carrier |
| rem | output | 1 | Gated carrier drive to the infrared emitter |
| sout_n | output | 1 | Low while a carrier burst is being driven |
| done | output | 1 | High while the counter is idle |
| done_pulse | output | 1 | One-clock pulse when a segment expires |

## Verification
Some properties are checked on every cycle: the carrier never appears with the indicator high, the expiry pulse lasts a single clock and coincides with the idle level, the idle level drops only after a load, and a stopped counter keeps the indicator high. Other behaviours can only be shown by the bench scenarios, which compare against lengths computed from tick-aligned loads. These are the exact segment lengths, the high-clock counts of each carrier against its divider, the frozen count under a low `run`, and the gapless chaining of two segments.

// File: rtl/ir_tmr_pkg.sv
package ir_tmr_pkg;
  localparam int CNT_W_DEF   = 9;
  localparam int MC_DIV_DEF  = 8;
  localparam int CAR_A_DEF   = 8;
  localparam int CAR_B_DEF   = 12;
  localparam int CAR_B_HI_DEF = 4;

  typedef enum logic {CAR_DIV_A = 1'b0, CAR_DIV_B = 1'b1} car_sel_e;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign tick = (phase == LAST);
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_tmr_pkg::*;
#(
  parameter int DIV_A = 8,
  parameter int DIV_B = 12,
  parameter int HI_B  = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  car_sel_e sel,
  output logic     car
);
  localparam int NDIV = 2;
  localparam int MAXD = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int DW   = $clog2(MAXD);

  logic [NDIV-1:0] wave;

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    localparam int D  = (g == 0) ? DIV_A : DIV_B;
    localparam int HI = (g == 0) ? DIV_A / 2 : HI_B;
    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else if (cnt == DW'(D - 1)) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    // divide-by-A: high in the upper half; divide-by-B: high in the first HI clocks
    if (g == 0) begin : g_sq
      assign wave[g] = (cnt >= DW'(HI));
    end else begin : g_third
      assign wave[g] = (cnt < DW'(HI));
    end
  end

  assign car = (sel == CAR_DIV_B) ? wave[1] : wave[0];
endmodule

// File: rtl/ir_burst_cnt.sv
module ir_burst_cnt #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W:0]   load_val,
  output logic             active,
  output logic             cen,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      cen    <= 1'b0;
      active <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        // a load on the expiring tick wins, so the segment continues unbroken
        cnt    <= load_val[CNT_W-1:0];
        cen    <= load_val[CNT_W];
        active <= 1'b1;
      end else if (active && run && tick) begin
        if (cnt == '0) begin
          active <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ir_burst_timer.sv
module ir_burst_timer
  import ir_tmr_pkg::*;
#(
  parameter int CNT_W    = CNT_W_DEF,
  parameter int MC_DIV   = MC_DIV_DEF,
  parameter int CAR_A    = CAR_A_DEF,
  parameter int CAR_B    = CAR_B_DEF,
  parameter int CAR_B_HI = CAR_B_HI_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W:0]   load_val,
  input  logic             run,
  input  logic             car_sel,
  output logic             rem,
  output logic             sout_n,
  output logic             done,
  output logic             done_pulse
);
  logic tick, car, active, cen, expire, burst;

  ir_tick_gen #(.DIV(MC_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  ir_carrier_gen #(.DIV_A(CAR_A), .DIV_B(CAR_B), .HI_B(CAR_B_HI)) u_car (
    .clk(clk),
    .rst(rst),
    .sel(car_sel_e'(car_sel)),
    .car(car)
  );

  ir_burst_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run     (run),
    .load    (load),
    .load_val(load_val),
    .active  (active),
    .cen     (cen),
    .expire  (expire)
  );

  assign burst = active && run && cen;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= 1'b0;
      sout_n <= 1'b1;
    end else begin
      rem    <= burst && car;
      sout_n <= !burst;
    end
  end

  assign done       = !active;
  assign done_pulse = expire;
endmodule

// File: rtl/ir_burst_timer_chk.sv
module ir_burst_timer_chk (
  input logic clk,
  input logic rst,
  input logic load,
  input logic run,
  input logic rem,
  input logic sout_n,
  input logic done,
  input logic done_pulse
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      reset_state_chk: assert (!rem && sout_n && done && !done_pulse);
    end
  end

  // R10
  carrier_needs_indicator_chk: assert property (@(posedge clk) disable iff (rst)
    rem |-> !sout_n);

  // R7
  pulse_single_clock_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  // R7
  pulse_with_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> done);

  // R7
  idle_only_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(load));

  // R8
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> (sout_n && !rem));

  // R3
  idle_no_carrier_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> !rem);
endmodule

bind ir_burst_timer ir_burst_timer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .run       (run),
  .rem       (rem),
  .sout_n    (sout_n),
  .done      (done),
  .done_pulse(done_pulse)
);

// File: tb/sim_ir_burst_timer.sv
`timescale 1ns/1ps
module sim_ir_burst_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [9:0] load_val = '0;
  logic       run = 1'b1;
  logic       car_sel = 1'b0;
  logic       rem, sout_n, done, done_pulse;

  always #2.5 clk = ~clk;

  ir_burst_timer u0 (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .run(run),
    .car_sel(car_sel), .rem(rem), .sout_n(sout_n), .done(done),
    .done_pulse(done_pulse)
  );

  int checks = 0;
  int fails  = 0;
  int ecount = 0;

  typedef struct {int req; int low; int hi; int pulses; int maxrun;} exp_t;
  exp_t sb[$];

  task automatic chk(input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // edge index since reset release; ticks fall on indices 8k+7
  always @(posedge clk) ecount <= rst ? 0 : ecount + 1;

  task automatic align();
    @(negedge clk);
    while (ecount % 8 != 7) @(negedge clk);
  endtask

  task automatic do_load(input logic [9:0] v);
    align();
    load = 1'b1; load_val = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic push(input int req, input int low, input int hi, input int pul, input int mr);
    exp_t e;
    e.req = req; e.low = low; e.hi = hi; e.pulses = pul; e.maxrun = mr;
    sb.push_back(e);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: measures each indicator-low burst and compares with the queue
  int mlow = 0, mhi = 0, mpul = 0, mrun = 0, mmax = 0, bad10 = 0;
  always @(negedge clk) begin
    if (rst) begin
      mlow = 0; mhi = 0; mpul = 0; mrun = 0; mmax = 0;
    end else begin
      if (rem && sout_n) bad10++;
      if (!sout_n) begin
        mlow++;
        if (done_pulse) mpul++;
        if (rem) begin
          mhi++; mrun++;
          if (mrun > mmax) mmax = mrun;
        end else mrun = 0;
      end else if (mlow > 0) begin
        if (sb.size() == 0) begin
          chk(3, mlow, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.req, mlow, e.low);
          if (e.hi >= 0) chk(e.req, mhi, e.hi);
          chk(7, mpul, e.pulses);
          if (e.maxrun >= 0) chk(e.req, mmax, e.maxrun);
        end
        mlow = 0; mhi = 0; mpul = 0; mrun = 0; mmax = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R0 watchdog actual 0 expected 1");
    finish_up();
  end

  initial begin
    int dlow, bad;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk(1, rem, 0); chk(1, sout_n, 1); chk(1, done, 1); chk(1, done_pulse, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(1, done, 1);

    // R2 R3 R5: carrier burst N=1 on divide-by-8
    push(3, 16, 8, 1, 4);
    do_load(10'h201);
    wait_idle();
    // R2 R5: N=5
    push(2, 48, 24, 1, 4);
    do_load(10'h205);
    wait_idle();

    // R6: divide-by-12, 24 and 72 clocks
    car_sel = 1'b1;
    push(6, 24, 8, 1, 4);
    do_load(10'h202);
    wait_idle();
    push(6, 72, 24, 1, 4);
    do_load(10'h208);
    wait_idle();
    car_sel = 1'b0;

    // R4: silent gap of N=3
    do_load(10'h003);
    dlow = 0; bad = 0;
    while (!done) begin
      dlow++;
      if (rem || !sout_n) bad++;
      @(negedge clk);
    end
    chk(4, bad, 0);
    chk(4, dlow, 32);

    // R7: idle level holds, no stray pulse
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (!done || done_pulse) bad++;
    end
    chk(7, bad, 0);

    // R8: frozen while run is low
    run = 1'b0;
    push(8, 9, -1, 1, -1);
    do_load(10'h201);
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (done || rem || !sout_n) bad++;
    end
    chk(8, bad, 0);
    align();
    run = 1'b1;
    wait_idle();

    // R9: reload on the expiring tick continues the burst
    push(9, 24, 12, 1, 4);
    do_load(10'h200);
    align();
    load = 1'b1; load_val = 10'h201;
    @(negedge clk);
    load = 1'b0;
    wait_idle();
    chk(9, sb.size(), 0);

    // R1: reset in the middle of a burst
    do_load(10'h210);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(1, rem, 0); chk(1, sout_n, 1); chk(1, done, 1); chk(1, done_pulse, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(1, done, 1);

    // R10: carrier never seen with indicator high
    chk(10, bad10, 0);
    finish_up();
  end
endmodule